// File: doc/BRIEF.md
# Windowed Watchdog Timeout Counter

This block is the counting core of a watchdog. An up-counter advances on a clock enable produced by a power-of-two prescaler. An optional low-power stage can slow that enable further or stop it. Two thresholds are compared against the count. One raises a timeout-interrupt event and the other raises a timeout-reset event. When the reset threshold is reached the counter stops and holds.

A refresh pulse arrives from an external unlock checker and normally clears the count. In window mode a refresh is accepted only inside a window placed within the timeout period:
- the opening point is a selectable number of sixteenths of the period;
- the width is a second selectable number of sixteenths.

A refresh outside the window does not clear the count. Instead it raises a refresh-violation event.

Four further error events come in as pulses from neighbouring logic. All events land in a seven-bit status register whose bits are cleared by writing ones. A 32-bit enable word gives each event its own interrupt enable and its own reset enable. The block drives one interrupt line and one reset request.

Top module: `wdt_window_core`

## Requirements
- R1: While `enable_i` is high and low power is inactive, `count_o` advances by one every 2^`div_exp_i` clock cycles. The first advance comes on the 2^`div_exp_i`-th rising edge after enable is first sampled high.
- R2: While `lp_act_i` is high, `lp_mode_i` selects how the prescaled enable is further divided:
  - 0 stops the count;
  - 1 divides it by 4;
  - 2 divides it by 2;
  - 3 leaves it undivided.
- R3: A cycle with `enable_i` low clears both the count and the prescaler state. A fresh run after re-enabling therefore starts a full prescale period.
- R4: Status bit 4 is set on the edge at which the count becomes `int_thr_i`. Status bit 5 is set on the edge at which the count becomes `rst_thr_i`. The count then holds at `rst_thr_i`.
- R5: With `win_en_i` low, a refresh while enabled clears the count to zero on the next edge and sets no status bit.
- R6: With `win_en_i` high and T = `rst_thr_i`, a refresh at count c is accepted when lo <= c < lo + w. Here lo = floor(T*(8+2*`win_lo_sel_i`)/16) and w = floor(T*(`win_hi_sel_i`+1)/16).
- R7: A refresh outside the window does not clear the count, which keeps counting. The refresh sets status bit 0.
- R8: `ext_evt_i` pulses set status bits as follows:
  - bit 0 (refresh unlock fail) sets status bit 1;
  - bit 1 (config update violation) sets status bit 2;
  - bit 2 (config unlock fail) sets status bit 3;
  - bit 3 (parity error) sets status bit 6.
- R9: A cycle with `clr_we_i` high clears every status bit where `clr_i` is one. An event set in the same cycle wins over the clear.
- R10: `irq_o` is the OR of each status bit ANDed with its interrupt enable in `en_mask_i`. The interrupt enables sit at these positions:
  - parity at bit 2 (status 6);
  - config unlock fail at bit 4 (status 3);
  - config update at bit 6 (status 2);
  - timeout at bit 16 (status 4);
  - refresh unlock fail at bit 20 (status 1);
  - refresh violation at bit 22 (status 0).

  `rst_req_o` is formed in the same way from the reset enables, each one bit above its interrupt enable. The timeout reset enable at bit 17 uses status bit 5. All other mask bits have no effect.
- R11: After reset the count and status are zero, and `irq_o` and `rst_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Work clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the counter; low clears count and prescaler |
| div_exp_i | input | DIV_W | Prescale exponent, divide by 2^value |
| lp_act_i | input | 1 | Low-power condition active |
| lp_mode_i | input | 2 | Low-power behaviour: 0 stop, 1 /4, 2 /2, 3 full rate |
| int_thr_i | input | CNT_W | Timeout-interrupt threshold in ticks |
| rst_thr_i | input | CNT_W | Timeout-reset threshold in ticks, also the window period |
| win_en_i | input | 1 | Window mode enable |
| win_lo_sel_i | input | 2 | Window opening: (8+2*sel)/16 of the period |
| win_hi_sel_i | input | 3 | Window width: (sel+1)/16 of the period |
| refresh_i | input | 1 | Refresh pulse from the unlock checker |
| ext_evt_i | input | 4 | External error event pulses |
| clr_we_i | input | 1 | Status write-one-to-clear strobe |
| clr_i | input | 7 | Status bits to clear |
| en_mask_i | input | 32 | Interrupt and reset enable word |
| count_o | output | CNT_W | Current count |
| status_o | output | 7 | Sticky event flags |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
The hardest states to reach are the exact window edges, where a refresh one tick early or one tick late must be treated differently. The bench reaches each one deterministically. It restarts the counter with a single-cycle prescaler and runs exactly c edges, for every combination of opening and width selector. It then pulses a refresh at four counts per combination: one below the opening, at the opening, at the last open tick and at the closing tick.

A second hard case is the state with all seven status bits set at once, which needs a timeout run, a late refresh and the external pulses together. The enable word is then walked one bit at a time so that each enable is matched to its own source bit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned STAT_W = 7;
  localparam int unsigned EV_N   = 6;

  localparam int unsigned ST_REF_VIOL = 0;
  localparam int unsigned ST_REF_ULK  = 1;
  localparam int unsigned ST_CFG_UPD  = 2;
  localparam int unsigned ST_CFG_ULK  = 3;
  localparam int unsigned ST_TO_INT   = 4;
  localparam int unsigned ST_TO_RST   = 5;
  localparam int unsigned ST_PARITY   = 6;

  // interrupt enable bit per event; reset enable is one above
  localparam int unsigned EV_IRQ_BIT [EV_N] = '{2, 4, 6, 16, 20, 22};
  localparam int unsigned EV_SRC_IRQ [EV_N] = '{ST_PARITY, ST_CFG_ULK, ST_CFG_UPD,
                                                ST_TO_INT, ST_REF_ULK, ST_REF_VIOL};
  localparam int unsigned EV_SRC_RST [EV_N] = '{ST_PARITY, ST_CFG_ULK, ST_CFG_UPD,
                                                ST_TO_RST, ST_REF_ULK, ST_REF_VIOL};

  typedef enum logic [1:0] {
    LP_HALT = 2'd0,
    LP_DIV4 = 2'd1,
    LP_DIV2 = 2'd2,
    LP_FULL = 2'd3
  } lp_mode_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] div_exp_i,
  input  logic             lp_act_i,
  input  logic [1:0]       lp_mode_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q, mask;
  logic [1:0]       lp_q;
  logic             base_tick;
  lp_mode_e         mode;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(div_exp_i));
  end

  assign base_tick = enable_i && ((pre_q & mask) == mask);
  assign mode      = lp_mode_e'(lp_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      lp_q  <= '0;
    end else if (!enable_i) begin
      pre_q <= '0;
      lp_q  <= '0;
    end else begin
      pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
      if (base_tick) lp_q <= lp_q + 2'd1;
    end
  end

  always_comb begin
    tick_o = base_tick;
    if (lp_act_i) begin
      unique case (mode)
        LP_HALT: tick_o = 1'b0;
        LP_DIV4: tick_o = base_tick && (lp_q == 2'd3);
        LP_DIV2: tick_o = base_tick && lp_q[0];
        LP_FULL: tick_o = base_tick;
        default: tick_o = 1'b0;
      endcase
    end
  end

  assert_pre_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pre_q == '0 && lp_q == 2'd0));
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             win_en_i,
  input  logic [1:0]       lo_sel_i,
  input  logic [2:0]       hi_sel_i,
  output logic             ok_o
);
  localparam int unsigned PW = CNT_W + 5;

  logic [PW-1:0]    per_x, lo_mul, hi_mul, lo_prod, hi_prod;
  logic [CNT_W-1:0] lo_ticks, hi_ticks;
  logic [CNT_W:0]   close_at;

  assign per_x    = {5'b0, period_i};
  assign lo_mul   = {{(PW-5){1'b0}}, 2'b01, lo_sel_i, 1'b0};
  assign hi_mul   = {{(PW-4){1'b0}}, 1'b0, hi_sel_i} + {{(PW-1){1'b0}}, 1'b1};
  assign lo_prod  = per_x * lo_mul;
  assign hi_prod  = per_x * hi_mul;
  assign lo_ticks = lo_prod[CNT_W+3:4];
  assign hi_ticks = hi_prod[CNT_W+3:4];
  assign close_at = {1'b0, lo_ticks} + {1'b0, hi_ticks};

  logic unused_prod;
  assign unused_prod = ^{lo_prod[PW-1:CNT_W+4], lo_prod[3:0], hi_prod[PW-1:CNT_W+4], hi_prod[3:0]};

  assign ok_o = !win_en_i || ((cnt_i >= lo_ticks) && ({1'b0, cnt_i} < close_at));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] int_thr_i,
  input  logic [CNT_W-1:0] rst_thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_int_o,
  output logic             hit_rst_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             at_limit, adv;

  assign cnt_inc   = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign at_limit  = cnt_q >= rst_thr_i;
  assign adv       = enable_i && tick_i && !reload_i && !at_limit;
  assign hit_int_o = adv && (cnt_inc == int_thr_i);
  assign hit_rst_o = adv && (cnt_inc == rst_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!enable_i || reload_i) cnt_q <= '0;
    else if (adv)                 cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;

  assert_clear_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> cnt_q == '0);
  assert_hold_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !reload_i && cnt_q >= rst_thr_i) |=> cnt_q == $past(cnt_q));
  assert_unit_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] status_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_eff) | set_i;
  end

  assign status_o = status_q;

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_q & $past(clr_i & ~set_i)) == '0));
  assert_set_sticks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/wdt_window_core.sv
module wdt_window_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] div_exp_i,
  input  logic             lp_act_i,
  input  logic [1:0]       lp_mode_i,
  input  logic [CNT_W-1:0] int_thr_i,
  input  logic [CNT_W-1:0] rst_thr_i,
  input  logic             win_en_i,
  input  logic [1:0]       win_lo_sel_i,
  input  logic [2:0]       win_hi_sel_i,
  input  logic             refresh_i,
  input  logic [3:0]       ext_evt_i,
  input  logic             clr_we_i,
  input  logic [6:0]       clr_i,
  input  logic [31:0]      en_mask_i,
  output logic [CNT_W-1:0] count_o,
  output logic [6:0]       status_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic             tick, win_ok, ref_ok, ref_bad, hit_int, hit_rst;
  logic [CNT_W-1:0] cnt;
  logic [STAT_W-1:0] set_vec, stat;
  logic [EV_N-1:0]  irq_vec, rst_vec;

  wdt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .enable_i, .div_exp_i, .lp_act_i, .lp_mode_i,
    .tick_o(tick)
  );

  wdt_window #(.CNT_W(CNT_W)) u_win (
    .cnt_i(cnt), .period_i(rst_thr_i), .win_en_i,
    .lo_sel_i(win_lo_sel_i), .hi_sel_i(win_hi_sel_i), .ok_o(win_ok)
  );

  assign ref_ok  = refresh_i && enable_i && win_ok;
  assign ref_bad = refresh_i && enable_i && !win_ok;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .enable_i, .tick_i(tick), .reload_i(ref_ok),
    .int_thr_i, .rst_thr_i, .cnt_o(cnt), .hit_int_o(hit_int), .hit_rst_o(hit_rst)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[ST_REF_VIOL] = ref_bad;
    set_vec[ST_REF_ULK]  = ext_evt_i[0];
    set_vec[ST_CFG_UPD]  = ext_evt_i[1];
    set_vec[ST_CFG_ULK]  = ext_evt_i[2];
    set_vec[ST_TO_INT]   = hit_int;
    set_vec[ST_TO_RST]   = hit_rst;
    set_vec[ST_PARITY]   = ext_evt_i[3];
  end

  wdt_status u_stat (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_we_i, .clr_i, .status_o(stat)
  );

  for (genvar g = 0; g < EV_N; g++) begin : g_ev
    assign irq_vec[g] = stat[EV_SRC_IRQ[g]] && en_mask_i[EV_IRQ_BIT[g]];
    assign rst_vec[g] = stat[EV_SRC_RST[g]] && en_mask_i[EV_IRQ_BIT[g] + 1];
  end

  logic unused_mask;
  assign unused_mask = ^en_mask_i;

  assign irq_o     = |irq_vec;
  assign rst_req_o = |rst_vec;
  assign count_o   = cnt;
  assign status_o  = stat;

  assert_valid_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && enable_i && win_ok) |=> count_o == '0);
  assert_viol_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && enable_i && !win_ok) |=> status_o[ST_REF_VIOL]);
  assert_quiet_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == '0) |-> (!irq_o && !rst_req_o));
endmodule

// File: tb/wdt_window_core_test.sv
`timescale 1ns/1ps
module wdt_window_core_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [3:0]    div_exp = '0;
  logic          lp_act = 1'b0;
  logic [1:0]    lp_mode = '0;
  logic [CW-1:0] int_thr = '1;
  logic [CW-1:0] rst_thr = 16'd1000;
  logic          win_en = 1'b0;
  logic [1:0]    lo_sel = '0;
  logic [2:0]    hi_sel = '0;
  logic          refresh = 1'b0;
  logic [3:0]    ext_evt = '0;
  logic          clr_we = 1'b0;
  logic [6:0]    clr = '0;
  logic [31:0]   en_mask = '0;
  logic [CW-1:0] count;
  logic [6:0]    status;
  logic          irq, rst_req;

  always #4 clk = ~clk;

  wdt_window_core uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .div_exp_i(div_exp),
    .lp_act_i(lp_act), .lp_mode_i(lp_mode), .int_thr_i(int_thr), .rst_thr_i(rst_thr),
    .win_en_i(win_en), .win_lo_sel_i(lo_sel), .win_hi_sel_i(hi_sel),
    .refresh_i(refresh), .ext_evt_i(ext_evt), .clr_we_i(clr_we), .clr_i(clr),
    .en_mask_i(en_mask), .count_o(count), .status_o(status), .irq_o(irq),
    .rst_req_o(rst_req)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    enable = 1'b0;
    step(1);
    enable = 1'b1;
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr = 7'h7f;
    step(1);
    clr_we = 1'b0; clr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int irq_pos [6] = '{2, 4, 6, 16, 20, 22};
    int ext_bit [4] = '{1, 2, 3, 6};
    en_mask = '1;
    step(3);
    check("R11 count", count, 0);
    check("R11 status", status, 0);
    check("R11 irq", irq, 0);
    check("R11 rst_req", rst_req, 0);
    rst_n = 1'b1;
    en_mask = '0;
    step(2);
    check("R11 idle count", count, 0);

    // prescaler and low-power sweep
    for (int e = 0; e < 4; e++) begin
      for (int cfg = 0; cfg < 5; cfg++) begin
        int sh;
        int expv;
        div_exp = 4'(e);
        lp_act  = (cfg != 0);
        lp_mode = (cfg == 0) ? 2'd0 : 2'(cfg - 1);
        sh      = (cfg == 2) ? 2 : (cfg == 3) ? 1 : 0;
        restart();
        step(37);
        expv = (cfg == 1) ? 0 : ((37 >> e) >> sh);
        check(cfg == 0 ? "R1 prescale" : "R2 low power", count, expv);
      end
    end
    lp_act = 1'b0;

    // disable clears count and prescaler
    enable = 1'b0;
    step(1);
    check("R3 off clears count", count, 0);
    div_exp = 4'd2;
    enable = 1'b1;
    step(3);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(3);
    check("R3 prescaler restarted", count, 0);
    step(1);
    check("R3 first tick", count, 1);

    // thresholds
    div_exp = 4'd0;
    int_thr = 16'd10;
    rst_thr = 16'd20;
    en_mask = (32'd1 << 16) | (32'd1 << 17);
    clear_all();
    restart();
    step(9);
    check("R4 int not yet", status[4], 0);
    check("R10 irq not yet", irq, 0);
    step(1);
    check("R4 int at threshold", status[4], 1);
    check("R10 irq on timeout", irq, 1);
    check("R10 no reset yet", rst_req, 0);
    step(10);
    check("R4 count at reset thr", count, 20);
    check("R4 reset flag", status[5], 1);
    check("R10 reset request", rst_req, 1);
    step(5);
    check("R4 hold at limit", count, 20);

    // write-one-to-clear
    clr_we = 1'b1; clr = 7'h10;
    step(1);
    clr_we = 1'b0; clr = '0;
    check("R9 clear bit 4 only", status, 7'h20);
    check("R9 irq drops", irq, 0);
    ext_evt = 4'b0001; clr_we = 1'b1; clr = 7'h02;
    step(1);
    ext_evt = '0; clr_we = 1'b0; clr = '0;
    check("R9 set beats clear", status[1], 1);

    // refresh without window
    int_thr = '1;
    rst_thr = 16'd1000;
    clear_all();
    restart();
    step(7);
    refresh = 1'b1;
    step(1);
    refresh = 1'b0;
    check("R5 refresh clears", count, 0);
    check("R5 no status", status, 0);
    refresh = 1'b1; enable = 1'b0;
    step(1);
    refresh = 1'b0;
    check("R5 refresh while off", status, 0);

    // window boundaries
    rst_thr = 16'd64;
    win_en  = 1'b1;
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = 0; hi < 8; hi++) begin
        int lo_t;
        int end_t;
        lo_t  = (64 * (8 + 2 * lo)) / 16;
        end_t = lo_t + (64 * (hi + 1)) / 16;
        lo_sel = 2'(lo);
        hi_sel = 3'(hi);
        for (int k = 0; k < 4; k++) begin
          int c;
          bit ok;
          c = (k == 0) ? lo_t - 1 : (k == 1) ? lo_t : (k == 2) ? end_t - 1 : end_t;
          if (c < 0 || c >= 64) continue;
          ok = (c >= lo_t) && (c < end_t);
          clear_all();
          restart();
          step(c);
          refresh = 1'b1;
          step(1);
          refresh = 1'b0;
          check(ok ? "R6 in-window reload" : "R7 late/early keeps count", count, ok ? 0 : c + 1);
          check(ok ? "R6 no violation" : "R7 violation flag", status[0], ok ? 0 : 1);
        end
      end
    end

    // external event mapping
    win_en = 1'b0;
    clear_all();
    for (int i = 0; i < 4; i++) begin
      ext_evt = 4'(1 << i);
      step(1);
      ext_evt = '0;
      check("R8 external event bit", status, 1 << ext_bit[i]);
      clear_all();
    end

    // all flags set, then walk the enable word
    rst_thr = 16'd20;
    int_thr = 16'd10;
    win_en  = 1'b1;
    lo_sel  = 2'd0;
    hi_sel  = 3'd0;
    restart();
    step(25);
    refresh = 1'b1;
    step(1);
    refresh = 1'b0;
    ext_evt = 4'hf;
    step(1);
    ext_evt = '0;
    check("R8 all flags", status, 7'h7f);
    for (int j = 0; j < 6; j++) begin
      en_mask = 32'd1 << irq_pos[j];
      #1;
      check("R10 irq enable", irq, 1);
      check("R10 irq only", rst_req, 0);
      en_mask = 32'd1 << (irq_pos[j] + 1);
      #1;
      check("R10 reset enable", rst_req, 1);
      check("R10 reset only", irq, 0);
    end
    en_mask = ~32'h00F300FC;
    #1;
    check("R10 other bits irq", irq, 0);
    check("R10 other bits rst", rst_req, 0);
    step(1);
    clr_we = 1'b1; clr = 7'h20;
    step(1);
    clr_we = 1'b0; clr = '0;
    en_mask = 32'd1 << 17;
    #1;
    check("R10 timeout reset source", rst_req, 0);
    en_mask = 32'd1 << 16;
    #1;
    check("R10 timeout irq source", irq, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule